// File: doc/BRIEF.md
# Memory-Backed LIFO Stack Controller

This block keeps a stack pointer and runs a last-in, first-out stack inside a word-wide synchronous RAM that uses byte addresses. A client issues one command at a time over a valid/ready port: reset the pointer to its start position, push an item, pop an item, or do nothing. Each item is a 32-bit word or a 16-bit halfword. The RAM side has an enable, a write strobe, per-byte write enables, a word index, write data and read data returned one cycle later.

Two static parameters set the growth convention. `FULL` chooses whether the pointer marks the newest item (1) or the next free slot (0). `ASCEND` chooses whether a push moves the pointer up (1) or down (0). Together they decide whether the pointer moves before or after the memory access. `BASE` is the starting pointer. A push is allowed only inside the byte window `[REGION_LO, REGION_HI)`. A pop may not move the pointer past `BASE`.

A push that would leave the window, a pop that would go past the start, or an access on a bad alignment completes with an error flag. It causes no RAM access and leaves the pointer unchanged. Every command ends with a one-cycle `done` pulse two cycles after it is accepted. The flags and the popped data are valid during that pulse.

Top module: `stack_ctrl`

## Requirements
- R1: After reset, and after an init command (`cmd_op` = 2'b00), `sp` equals `BASE`. Init completes with no error flag.
- R2: `cmd_ready` is high only while the block is idle, and a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low in the cycle after acceptance. `done` is high for exactly one cycle, the second cycle after acceptance.
- R3: In full mode, a push (`cmd_op` = 2'b01) first moves the pointer by the item size and then writes the item at the new pointer. A pop (`cmd_op` = 2'b10) reads at the current pointer and then moves it back.
- R4: Popped items come back in exact reverse order of their pushes.
- R5: In empty mode, a push writes at the current pointer and then moves it. A pop first moves the pointer back and then reads at the new pointer.
- R6: The pointer step is 4 for a word and 2 for a halfword (`cmd_half` = 1). RAM words are little-endian: a halfword at a byte address with bit 1 set uses bits 31:16, and one with bit 1 clear uses bits 15:0. A popped halfword is zero-extended.
- R7: A push whose item bytes would not all lie in `[REGION_LO, REGION_HI)` raises `err_ovf`. No RAM write takes place and `sp` is unchanged.
- R8: A pop that would move the pointer past `BASE` raises `err_unf`. This means above `BASE` when descending and below `BASE` when ascending. `sp` is unchanged.
- R9: An access to a word address with a nonzero remainder mod 4, or to a halfword at an odd address, raises `err_mis`. The access is suppressed and `sp` is unchanged.
- R10: `cmd_op` = 2'b11 is a no-op. It completes with `done`, raises no flag and leaves `sp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 00 init, 01 push, 10 pop, 11 no-op |
| cmd_half | input | 1 | Item is a halfword (1) or a word (0) |
| push_data | input | 32 | Item to push (low 16 bits for halfword) |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 32 | Popped item, valid with `done` |
| err_ovf | output | 1 | Push out of region, valid with `done` |
| err_unf | output | 1 | Pop past start, valid with `done` |
| err_mis | output | 1 | Misaligned access, valid with `done` |
| sp | output | ADDR_W | Current stack pointer |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write strobe |
| ram_be | output | 4 | RAM byte write enables |
| ram_addr | output | ADDR_W-2 | RAM word index |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after a read |

## Verification
Two instances run side by side on the same commands: one full-descending and one empty-ascending. This shows whether the pointer update comes before or after the access. A design with the order swapped would return the wrong slot, or data one item off. Directed sequences fill the region to its last slot and then push once more, and pop an empty stack. A design with an off-by-one bound would either corrupt memory next to the region or refuse a legal item. Mixing halfword and word items breaks word alignment. A design that did not suppress that access would write a word across a lane boundary and move the pointer. Long random runs check halfword lane selection and zero extension against a byte-level model.

// File: rtl/stack_ctrl.sv
module stack_ctrl #(
  parameter int ADDR_W = 16,
  parameter bit FULL   = 1'b1,
  parameter bit ASCEND = 1'b0,
  parameter logic [ADDR_W-1:0] REGION_LO = 16'h0100,
  parameter logic [ADDR_W-1:0] REGION_HI = 16'h0140,
  parameter logic [ADDR_W-1:0] BASE      = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_half,
  input  logic [31:0]       push_data,
  output logic              done,
  output logic [31:0]       pop_data,
  output logic              err_ovf,
  output logic              err_unf,
  output logic              err_mis,
  output logic [ADDR_W-1:0] sp,
  output logic              ram_en,
  output logic              ram_we,
  output logic [3:0]        ram_be,
  output logic [ADDR_W-3:0] ram_addr,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata
);
  localparam int XW = ADDR_W + 1;
  localparam logic [1:0] OP_INIT = 2'b00, OP_PUSH = 2'b01, OP_POP = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_FIN} state_t;
  state_t state;

  logic [1:0]  op_q;
  logic        half_q, rd_half, rd_hi;
  logic [31:0] data_q;
  logic        ovf_q, unf_q, mis_q;
  logic [XW-1:0] step, nsp_x, acc_x;
  logic is_push, is_pop, up, ovf, unf, mis, ok;

  assign is_push = (op_q == OP_PUSH);
  assign is_pop  = (op_q == OP_POP);
  assign step    = half_q ? XW'(2) : XW'(4);
  assign up      = (ASCEND == is_push);
  assign nsp_x   = up ? {1'b0, sp} + step : {1'b0, sp} - step;
  assign acc_x   = (FULL == is_push) ? nsp_x : {1'b0, sp};

  assign ovf = is_push && ((acc_x < {1'b0, REGION_LO}) || (acc_x + step > {1'b0, REGION_HI}));
  assign unf = is_pop && (ASCEND ? (nsp_x[ADDR_W] || nsp_x < {1'b0, BASE})
                                 : (nsp_x > {1'b0, BASE}));
  assign mis = (is_push || is_pop) && (half_q ? acc_x[0] : (acc_x[1:0] != 2'b00));
  assign ok  = !(ovf || unf || mis);

  assign cmd_ready = (state == S_IDLE);
  assign done      = (state == S_FIN);
  assign ram_en    = (state == S_EXEC) && (is_push || is_pop) && ok;
  assign ram_we    = is_push;
  assign ram_addr  = acc_x[ADDR_W-1:2];
  assign ram_be    = half_q ? (acc_x[1] ? 4'b1100 : 4'b0011) : 4'b1111;
  assign ram_wdata = half_q ? {2{data_q[15:0]}} : data_q;
  assign pop_data  = rd_half ? {16'h0, rd_hi ? ram_rdata[31:16] : ram_rdata[15:0]} : ram_rdata;
  assign err_ovf   = done && ovf_q;
  assign err_unf   = done && unf_q;
  assign err_mis   = done && mis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sp <= BASE;
      op_q <= 2'b11;
      half_q <= 1'b0;
      data_q <= '0;
      {ovf_q, unf_q, mis_q} <= 3'b000;
      rd_half <= 1'b0;
      rd_hi <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op;
          half_q <= cmd_half;
          data_q <= push_data;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (op_q == OP_INIT) sp <= BASE;
          else if ((is_push || is_pop) && ok) sp <= nsp_x[ADDR_W-1:0];
          {ovf_q, unf_q, mis_q} <= {ovf, unf, mis};
          rd_half <= half_q;
          rd_hi <= acc_x[1];
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_init_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && op_q == OP_INIT) |=> sp == BASE);
  // R8 and R9 are covered by the same hold check
  p_hold_on_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ovf_q || unf_q || mis_q)) |-> sp == $past(sp));
  p_push_direction_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |=> (ASCEND ? (sp > $past(sp)) : (sp < $past(sp))));
  p_lane_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> ($countones(ram_be) == 2 || $countones(ram_be) == 4));
endmodule

// File: tb/stack_ctrl_tb.sv
module stack_ram_model (
  input  logic        clk,
  input  logic        en,
  input  logic        we,
  input  logic [3:0]  be,
  input  logic [13:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0] mem [256];
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rdata = '0;
  end
  always @(posedge clk) if (en) begin
    if (we) begin
      for (int b = 0; b < 4; b++) if (be[b]) mem[addr[7:0]][8*b +: 8] <= wdata[8*b +: 8];
    end
    rdata <= mem[addr[7:0]];
  end
endmodule

module stack_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_half = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic [31:0] cmd_data = '0;

  logic rdy0, done0, ovf0, unf0, mis0, en0, we0;
  logic rdy1, done1, ovf1, unf1, mis1, en1, we1;
  logic [31:0] pd0, pd1, wd0, wd1, rd0, rd1;
  logic [15:0] sp0, sp1;
  logic [3:0] be0, be1;
  logic [13:0] ra0, ra1;

  int tests = 0, fails = 0;
  logic [7:0] mmem [2][1024];
  int msp [2];

  stack_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy0),
    .cmd_op(cmd_op), .cmd_half(cmd_half), .push_data(cmd_data), .done(done0), .pop_data(pd0),
    .err_ovf(ovf0), .err_unf(unf0), .err_mis(mis0), .sp(sp0), .ram_en(en0), .ram_we(we0),
    .ram_be(be0), .ram_addr(ra0), .ram_wdata(wd0), .ram_rdata(rd0));
  stack_ram_model u_ram0 (.clk(clk), .en(en0), .we(we0), .be(be0), .addr(ra0), .wdata(wd0), .rdata(rd0));

  stack_ctrl #(.FULL(1'b0), .ASCEND(1'b1), .REGION_LO(16'h0200), .REGION_HI(16'h0240),
    .BASE(16'h0200)) u_dut_ea (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy1),
    .cmd_op(cmd_op), .cmd_half(cmd_half), .push_data(cmd_data), .done(done1), .pop_data(pd1),
    .err_ovf(ovf1), .err_unf(unf1), .err_mis(mis1), .sp(sp1), .ram_en(en1), .ram_we(we1),
    .ram_be(be1), .ram_addr(ra1), .ram_wdata(wd1), .ram_rdata(rd1));
  stack_ram_model u_ram1 (.clk(clk), .en(en1), .we(we1), .be(be1), .addr(ra1), .wdata(wd1), .rdata(rd1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(int k, logic [1:0] op, bit half, logic [31:0] d,
                       output bit eo, output bit eu, output bit em, output logic [31:0] ed);
    int step, lo, hi, base, s, ns, acc;
    bit full, asc, push, pop, up;
    step = half ? 2 : 4;
    full = (k == 0); asc = (k == 1);
    lo = k ? 'h200 : 'h100; hi = k ? 'h240 : 'h140; base = k ? 'h200 : 'h140;
    push = (op == 2'b01); pop = (op == 2'b10);
    eo = 0; eu = 0; em = 0; ed = '0;
    s = msp[k];
    if (op == 2'b00) msp[k] = base;
    else if (push || pop) begin
      up = (asc == push);
      ns = up ? s + step : s - step;
      acc = (full == push) ? ns : s;
      if (push) eo = (acc < lo) || (acc + step > hi);
      if (pop) eu = asc ? (ns < base) : (ns > base);
      em = half ? (acc % 2 != 0) : (acc % 4 != 0);
      if (!(eo || eu || em)) begin
        for (int i = 0; i < step; i++)
          if (push) mmem[k][acc + i] = d[8*i +: 8];
          else ed[8*i +: 8] = mmem[k][acc + i];
        msp[k] = ns;
      end
    end
  endtask

  task automatic do_cmd(logic [1:0] op, bit half, logic [31:0] d, string tag);
    bit eo[2], eu[2], em[2];
    logic [31:0] ed[2];
    @(negedge clk);
    chk({tag, " R2 ready idle u_dut"}, rdy0, 1'b1);
    chk({tag, " R2 ready idle u_dut_ea"}, rdy1, 1'b1);
    cmd_valid = 1'b1; cmd_op = op; cmd_half = half; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " R2 busy"}, {rdy0, rdy1, done0, done1}, 4'b0000);
    for (int k = 0; k < 2; k++) model(k, op, half, d, eo[k], eu[k], em[k], ed[k]);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 done pulse"}, {done0, done1}, 2'b11);
    chk({tag, " R1 R3 R5 R6 sp u_dut"}, sp0, msp[0][15:0]);
    chk({tag, " R1 R3 R5 R6 sp u_dut_ea"}, sp1, msp[1][15:0]);
    chk({tag, " R7 R8 R9 R10 flags u_dut"}, {ovf0, unf0, mis0}, {eo[0], eu[0], em[0]});
    chk({tag, " R7 R8 R9 R10 flags u_dut_ea"}, {ovf1, unf1, mis1}, {eo[1], eu[1], em[1]});
    if (op == 2'b10 && !(eu[0] || em[0])) chk({tag, " R4 R6 pop data u_dut"}, pd0, ed[0]);
    if (op == 2'b10 && !(eu[1] || em[1])) chk({tag, " R4 R6 pop data u_dut_ea"}, pd1, ed[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r;
    msp[0] = 'h140; msp[1] = 'h200;
    for (int k = 0; k < 2; k++) for (int a = 0; a < 1024; a++) mmem[k][a] = 8'h00;
    r = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sp u_dut", sp0, 16'h0140);
    chk("R1 reset sp u_dut_ea", sp1, 16'h0200);
    chk("R2 reset ready/done", {rdy0, rdy1, done0, done1}, 4'b1100);

    do_cmd(2'b11, 0, 32'hdead, "R10 nop");
    do_cmd(2'b01, 0, 32'h45, "R3 push");
    do_cmd(2'b01, 0, 32'h7b, "R3 push");
    do_cmd(2'b01, 0, 32'h19, "R3 push");
    repeat (3) do_cmd(2'b10, 0, 0, "R4 lifo pop");
    do_cmd(2'b01, 1, 32'hBEEF, "R6 half push");
    do_cmd(2'b01, 1, 32'h1234, "R6 half push");
    do_cmd(2'b10, 1, 0, "R6 half pop");
    do_cmd(2'b10, 1, 0, "R6 half pop");
    do_cmd(2'b01, 1, 32'h0a0b, "R9 setup");
    do_cmd(2'b01, 0, 32'h11223344, "R9 misaligned push");
    do_cmd(2'b10, 0, 0, "R9 misaligned pop");
    do_cmd(2'b10, 1, 0, "R8 drain");
    do_cmd(2'b10, 0, 0, "R8 empty pop");
    do_cmd(2'b10, 1, 0, "R8 empty half pop");
    for (int i = 0; i < 16; i++) do_cmd(2'b01, 0, 32'hA000 + i, "R7 fill");
    do_cmd(2'b01, 0, 32'hFFFF, "R7 overflow push");
    do_cmd(2'b01, 1, 32'hFFFF, "R7 overflow half push");
    do_cmd(2'b10, 0, 0, "R7 top intact");
    do_cmd(2'b00, 0, 0, "R1 init");

    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = $urandom % 32;
      if (sel == 0) do_cmd(2'b00, 0, 0, "R1 rnd init");
      else if (sel == 1) do_cmd(2'b11, 0, $urandom, "R10 rnd nop");
      else if (sel < 17) do_cmd(2'b01, ($urandom % 4) == 0, $urandom, "R3 R5 rnd push");
      else do_cmd(2'b10, ($urandom % 4) == 0, 0, "R4 R5 rnd pop");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule